// File: doc/BRIEF.md
# Store-versus-hoisted-load alias guard

This block lets a scheduler move loads above stores that might write the same memory. When a load is moved above such a store, it is issued as a guarded load. A guarded load writes its byte address and access width into a table slot that the operation names. Later, a store that might conflict is issued as a checked store. A checked store carries its own address and width and a slot mask. The block compares the store's byte range against each slot that the mask selects and that holds a live entry. If any of those ranges intersect, the block flags an alias fault and returns a vector naming the slots that conflict. The consumer then reissues those loads.

A commit operation empties the whole table. Handling the fault and re-running the loads happen outside this block.

Operations arrive on a single request channel that uses valid/ready. Each request is one operation. The block never applies back-pressure: `req_ready` is high in every cycle after reset, so an operation is consumed in any cycle in which `req_valid` is high.

The fault response is combinational. It belongs to the request present in the same cycle. A guarded load or a commit takes effect at the clock edge that ends its cycle, so a store issued in a later cycle sees its result.

Byte ranges are the half-open intervals [addr, addr+bytes). They are computed one bit wider than the address, so ranges do not wrap around the top of the address space.

Top module: `alias_guard_table`

## Requirements
- R1: After reset every slot is empty, so a checked store with any mask gives `fault`=0 and `fault_slots`=0.
- R2: A guarded load (`req_op`=1) records `req_addr` and `req_size` into slot `req_slot` and marks it live. A later checked store whose range intersects it, with that slot selected, faults.
- R3: Intersection is tested on half-open byte ranges. A store ending exactly where a load starts, or starting exactly where it ends, does not fault.
- R4: `req_size` gives the byte count as a power of two: 0 is 1 byte, 1 is 2, 2 is 4 and 3 is 8. A store anywhere inside an 8-byte load range faults.
- R5: A checked store (`req_op`=2) compares only slots whose `req_mask` bit is 1. An unselected slot never appears in `fault_slots`, even when its addresses match.
- R6: A slot that is not live is never reported, whatever its mask bit.
- R7: A commit (`req_op`=3) empties all slots from the next cycle onward.
- R8: In the cycle of a checked store, `fault_slots` bit i is 1 exactly when slot i is selected, live and intersecting. `fault` is 1 exactly when any bit of `fault_slots` is 1.
- R9: When no checked store is presented (`req_valid`=0, or an op of 0, 1 or 3), `fault` and `fault_slots` are 0.
- R10: A guarded load into a slot that is already live replaces the old address and width.
- R11: `req_ready` is 1 in every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_op | input | 2 | 0 idle, 1 guarded load, 2 checked store, 3 commit |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Width code: 2**code bytes |
| req_slot | input | SLOT_W | Slot written by a guarded load |
| req_mask | input | SLOTS | Slots checked by a checked store |
| fault | output | 1 | Alias fault for the current checked store |
| fault_slots | output | SLOTS | Slots that conflict with the current checked store |

## Verification
The assertions check three things on every cycle:
- A reported slot is always selected and live.
- Nothing is reported outside a checked store.
- A commit leaves the table empty, and a guarded load leaves its slot live.

Only the bench's scenarios can show that intersection is exact at range edges for every width. The same holds for replacing a slot's contents and for a store that hits two slots at once. The bench compares against an independent table model.

// File: rtl/alias_pkg.sv
package alias_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_GUARD = 2'd1,
    OP_STORE = 2'd2,
    OP_FLUSH = 2'd3
  } alias_op_e;
endpackage

// File: rtl/alias_slot_store.sv
module alias_slot_store #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int SLOT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [1:0]                    wr_size,
  input  logic                          flush,
  output logic [SLOTS-1:0]              live,
  output logic [SLOTS-1:0][ADDR_W-1:0]  base_q,
  output logic [SLOTS-1:0][1:0]         size_q
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic pick;
    assign pick = wr_en && (wr_slot == SLOT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[i]   <= 1'b0;
        base_q[i] <= '0;
        size_q[i] <= '0;
      end else if (flush) begin
        live[i]   <= 1'b0;
      end else if (pick) begin
        live[i]   <= 1'b1;
        base_q[i] <= wr_addr;
        size_q[i] <= wr_size;
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live == '0)); // R7
endmodule

// File: rtl/alias_overlap_cmp.sv
module alias_overlap_cmp #(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [1:0]                    st_size,
  input  logic [SLOTS-1:0]              sel,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  base_q,
  input  logic [SLOTS-1:0][1:0]         size_q,
  output logic [SLOTS-1:0]              hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] st_lo, st_hi;
  assign st_lo = {1'b0, st_addr};
  assign st_hi = st_lo + (EW'(1) << st_size);

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    logic [EW-1:0] ld_lo, ld_hi;
    assign ld_lo  = {1'b0, base_q[i]};
    assign ld_hi  = ld_lo + (EW'(1) << size_q[i]);
    assign hit[i] = sel[i] && (st_lo < ld_hi) && (ld_lo < st_hi);
  end
endmodule

// File: rtl/alias_guard_table.sv
module alias_guard_table
  import alias_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 32,
  parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [SLOTS-1:0]  req_mask,
  output logic              fault,
  output logic [SLOTS-1:0]  fault_slots
);
  alias_op_e op;
  logic      is_guard, is_store, is_flush;
  logic [SLOTS-1:0]             live;
  logic [SLOTS-1:0][ADDR_W-1:0] base_q;
  logic [SLOTS-1:0][1:0]        size_q;
  logic [SLOTS-1:0]             sel;

  assign op        = alias_op_e'(req_op);
  assign req_ready = 1'b1;
  assign is_guard  = req_valid && (op == OP_GUARD);
  assign is_store  = req_valid && (op == OP_STORE);
  assign is_flush  = req_valid && (op == OP_FLUSH);

  alias_slot_store #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(is_guard), .wr_slot(req_slot), .wr_addr(req_addr), .wr_size(req_size),
    .flush(is_flush),
    .live(live), .base_q(base_q), .size_q(size_q)
  );

  assign sel = req_mask & live & {SLOTS{is_store}};

  alias_overlap_cmp #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_cmp (
    .st_addr(req_addr), .st_size(req_size), .sel(sel),
    .base_q(base_q), .size_q(size_q), .hit(fault_slots)
  );

  assign fault = |fault_slots;

  AST_VEC_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_slots & ~req_mask) == '0); // R5
  AST_VEC_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_slots & ~live) == '0); // R6
  AST_QUIET_OFF_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store |-> (fault_slots == '0)); // R9
  AST_GUARD_GOES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_guard && !is_flush) |=> live[$past(req_slot)]); // R2
endmodule

// File: tb/tb_alias_guard_table.sv
module tb_alias_guard_table;
  localparam int SLOTS  = 8;
  localparam int ADDR_W = 16;
  localparam int SLOT_W = 3;
  localparam int CLK_P  = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0, req_size = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [SLOT_W-1:0] req_slot = 0;
  logic [SLOTS-1:0]  req_mask = 0, fault_slots;
  logic fault;
  int checks = 0, fails = 0;

  logic              m_live [SLOTS];
  int unsigned       m_base [SLOTS];
  int unsigned       m_size [SLOTS];

  always #(CLK_P/2) clk = ~clk;

  alias_guard_table #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_slot(req_slot), .req_mask(req_mask),
    .fault(fault), .fault_slots(fault_slots));

  function automatic logic [SLOTS-1:0] expect_vec(logic v, logic [1:0] op,
      int unsigned a, int unsigned sz, logic [SLOTS-1:0] m);
    logic [SLOTS-1:0] r = '0;
    int unsigned nb = 1 << sz;
    if (v && op == 2'd2)
      for (int i = 0; i < SLOTS; i++)
        if (m[i] && m_live[i] && a < m_base[i] + (1 << m_size[i]) && m_base[i] < a + nb)
          r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [SLOTS-1:0] act, logic [SLOTS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, logic v, logic [1:0] op, int unsigned a,
      int unsigned sz, int unsigned slot, logic [SLOTS-1:0] m);
    logic [SLOTS-1:0] e;
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = ADDR_W'(a); req_size = 2'(sz);
    req_slot = SLOT_W'(slot); req_mask = m;
    #(CLK_P/4);
    e = expect_vec(v, op, a, sz, m);
    check({tag, " R8 vec"}, fault_slots, e);
    check({tag, " R8 fault"}, {{(SLOTS-1){1'b0}}, fault}, {{(SLOTS-1){1'b0}}, |e});
    check({tag, " R11 ready"}, {{(SLOTS-1){1'b0}}, req_ready}, {{(SLOTS-1){1'b0}}, 1'b1});
    @(posedge clk);
    if (v && op == 2'd1) begin
      m_live[slot] = 1'b1; m_base[slot] = a; m_size[slot] = sz;
    end else if (v && op == 2'd3) begin
      for (int i = 0; i < SLOTS; i++) m_live[i] = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A5E));
    for (int i = 0; i < SLOTS; i++) begin m_live[i] = 0; m_base[i] = 0; m_size[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: empty after reset
    issue("R1 reset", 1, 2, 'h100, 3, 0, 8'hFF);
    check("R1 fault after reset", {7'b0, fault}, 8'b0);
    // R2, R8: two slots hit by one store
    issue("R2 load0", 1, 1, 'h100, 2, 0, 0);
    issue("R2 load3", 1, 1, 'h102, 1, 3, 0);
    issue("R2 two-hit store", 1, 2, 'h102, 0, 0, 8'h09);
    check("R2 two-hit vector", fault_slots, 8'h09);
    // R3: adjacent edges
    issue("R3 below", 1, 2, 'h0FC, 2, 0, 8'h01);
    issue("R3 above", 1, 2, 'h104, 2, 0, 8'h01);
    // R4: 8-byte load, store at its last byte
    issue("R4 load8", 1, 1, 'h200, 3, 5, 0);
    issue("R4 last byte", 1, 2, 'h207, 0, 0, 8'h20);
    issue("R4 past end", 1, 2, 'h208, 0, 0, 8'h20);
    // R5: matching but unselected
    issue("R5 unselected", 1, 2, 'h100, 3, 0, 8'hDE);
    // R9: non-store ops give nothing
    issue("R9 load op", 1, 1, 'h100, 3, 1, 8'hFF);
    issue("R9 idle valid", 1, 0, 'h100, 3, 0, 8'hFF);
    issue("R9 not valid", 0, 2, 'h100, 3, 0, 8'hFF);
    // R10: overwrite slot 0 moves it away
    issue("R10 reload", 1, 1, 'h300, 0, 0, 0);
    issue("R10 old addr", 1, 2, 'h100, 0, 0, 8'h01);
    issue("R10 new addr", 1, 2, 'h300, 0, 0, 8'h01);
    // R7, R6: commit empties, invalid slots ignored
    issue("R7 commit", 1, 3, 0, 0, 0, 0);
    issue("R6 after commit", 1, 2, 'h300, 3, 0, 8'hFF);
    // random mix, R2..R10
    for (int n = 0; n < 3000; n++) begin
      int unsigned r = $urandom % 100;
      logic [1:0] op = (r < 40) ? 2'd1 : (r < 95) ? 2'd2 : (r < 97) ? 2'd3 : 2'd0;
      issue("rand", ($urandom % 16) != 0, op, 'h400 + ($urandom % 40),
            $urandom % 4, $urandom % SLOTS, SLOTS'($urandom));
    end
    @(negedge clk); req_valid = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule